// File: doc/BRIEF.md
# Half-Duplex Collision Indicator with Test Mode and Heartbeat

This block drives the media-independent collision output of a Fast Ethernet transceiver. In half-duplex operation it raises the collision flag whenever the local transmitter and the receive path are busy at the same time. The flag stays up for as long as that overlap lasts. In full-duplex operation the flag is held low.

A collision-test mode lets a MAC check its collision handling without a real line event. In this mode a transmit request alone raises the flag after a fixed number of bit times, and the flag drops a short, fixed time after the request ends. At 10 Mb/s the block also sends a heartbeat after every transmitted frame. This is a single flag pulse of fixed width that follows a fixed quiet gap, and it tells the MAC that the transmit path is working. A control bit can turn the heartbeat off.

All timing is counted in bit-time strobes supplied by the surrounding logic on a single-cycle `bit_tick` input. All inputs are synchronous to `clk`.

Top module: `mii_col_unit`

## Requirements
- R1: In half duplex, with `tx_en` and `rx_act` both high, `col` is high on the clock after that overlap is sampled. It is low on the clock after either input drops, unless another source holds it.
- R2: With `full_dup` high, `col` is low on the next clock, whatever the other inputs are, including during an overlap that is already in progress.
- R3: With `ctest_en` high, a rising `tx_en` with `rx_act` low raises `col` on the clock after the 64th `bit_tick` counted after the rise. After 63 strobes, `col` is still low.
- R4: In test mode, after `tx_en` falls, `col` stays high through the first following `bit_tick`. It is low on the clock after the 2nd strobe.
- R5: With `ctest_en` low and `rx_act` low, a transmit request never raises `col`, however long it lasts.
- R6: At 10 Mb/s (`speed10` high), in half duplex with `sqe_off` low, the heartbeat raises `col` on the clock after the 20th `bit_tick` following the fall of `tx_en`. After 19 strobes, `col` is still low.
- R7: The heartbeat lasts 10 bit times. `col` is still high after 9 further strobes and low on the clock after the 10th.
- R8: With `sqe_off` high when `tx_en` falls, no heartbeat is produced.
- R9: No heartbeat is produced when `speed10` is low or `full_dup` is high at the time `tx_en` falls.
- R10: If `tx_en` rises again during the quiet gap before the heartbeat, the pending heartbeat is dropped and `col` stays low.
- R11: While reset is applied, and right after it is released, `col` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bit_tick | input | 1 | One-cycle strobe per bit time |
| tx_en | input | 1 | Transmit request from the MAC |
| rx_act | input | 1 | Receive activity from the line side |
| full_dup | input | 1 | High in full-duplex operation |
| speed10 | input | 1 | High at 10 Mb/s |
| ctest_en | input | 1 | Collision-test mode enable |
| sqe_off | input | 1 | Heartbeat disable |
| col | output | 1 | Collision indication |

## Verification
The output register adds exactly one clock to every path. An overlap or a full-duplex change therefore appears on `col` one clock after it is driven. A timed event appears one clock after the `bit_tick` that completes its count. The bench drives each strobe on a falling edge and lets one more full clock pass before it samples `col`. It checks every window at the strobe just before the boundary and again at the boundary itself. This catches a count that is off by one in either direction. The edge that starts a timing window is always followed by a clock with no strobe, so each window begins at a known point in its count.

// File: rtl/mcol_pkg.sv
package mcol_pkg;

  typedef enum logic [1:0] {
    TS_IDLE = 2'd0,
    TS_ARM  = 2'd1,
    TS_ON   = 2'd2,
    TS_HOLD = 2'd3
  } tst_st_t;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_GAP   = 2'd1,
    SQ_PULSE = 2'd2
  } sqe_st_t;

  function automatic int max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/mcol_rst_sync.sv
module mcol_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sh_q[STAGES-1];

endmodule

// File: rtl/mcol_test_timer.sv
module mcol_test_timer
  import mcol_pkg::*;
#(
  parameter int ON_DLY  = 64,
  parameter int OFF_DLY = 2,
  parameter int CW      = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic en,
  input  logic tx_en,
  input  logic tx_rise,
  output logic test_col
);

  localparam logic [CW-1:0] ON_LAST  = CW'(ON_DLY - 1);
  localparam logic [CW-1:0] OFF_LAST = CW'(OFF_DLY - 1);

  tst_st_t       st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    case (st_q)
      TS_IDLE: begin
        if (tx_rise) begin
          st_d  = TS_ARM;
          cnt_d = '0;
        end
      end
      TS_ARM: begin
        if (!tx_en) begin
          st_d = TS_IDLE;
        end else if (tick) begin
          if (cnt_q == ON_LAST) begin
            st_d  = TS_ON;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      TS_ON: begin
        if (!tx_en) begin
          st_d  = TS_HOLD;
          cnt_d = '0;
        end
      end
      TS_HOLD: begin
        if (tx_en) begin
          st_d = TS_ON;
        end else if (tick) begin
          if (cnt_q == OFF_LAST) st_d = TS_IDLE;
          else                   cnt_d = cnt_q + 1'b1;
        end
      end
      default: st_d = TS_IDLE;
    endcase
    if (!en) st_d = TS_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= TS_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign test_col = (st_q == TS_ON) || (st_q == TS_HOLD);

endmodule

// File: rtl/mcol_sqe_timer.sv
module mcol_sqe_timer
  import mcol_pkg::*;
#(
  parameter int GAP_LEN   = 20,
  parameter int PULSE_LEN = 10,
  parameter int CW        = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic tx_en,
  input  logic tx_fall,
  input  logic arm_ok,
  output logic sqe_col
);

  localparam logic [CW-1:0] GAP_LAST   = CW'(GAP_LEN - 1);
  localparam logic [CW-1:0] PULSE_LAST = CW'(PULSE_LEN - 1);

  sqe_st_t       st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    case (st_q)
      SQ_IDLE: begin
        if (tx_fall && arm_ok) begin
          st_d  = SQ_GAP;
          cnt_d = '0;
        end
      end
      SQ_GAP: begin
        if (tx_en) begin
          st_d = SQ_IDLE;
        end else if (tick) begin
          if (cnt_q == GAP_LAST) begin
            st_d  = SQ_PULSE;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      SQ_PULSE: begin
        if (tick) begin
          if (cnt_q == PULSE_LAST) st_d = SQ_IDLE;
          else                     cnt_d = cnt_q + 1'b1;
        end
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SQ_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign sqe_col = (st_q == SQ_PULSE);

endmodule

// File: rtl/mcol_out.sv
module mcol_out (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_en,
  input  logic rx_act,
  input  logic full_dup,
  input  logic test_col,
  input  logic sqe_col,
  output logic col
);

  logic col_d;

  always_comb begin
    col_d = ((tx_en && rx_act) || test_col || sqe_col) && !full_dup;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) col <= 1'b0;
    else        col <= col_d;
  end

endmodule

// File: rtl/mii_col_unit.sv
module mii_col_unit
  import mcol_pkg::*;
#(
  parameter int TEST_ON_DLY  = 64,
  parameter int TEST_OFF_DLY = 2,
  parameter int SQE_GAP      = 20,
  parameter int SQE_LEN      = 10,
  parameter int RST_STAGES   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_tick,
  input  logic tx_en,
  input  logic rx_act,
  input  logic full_dup,
  input  logic speed10,
  input  logic ctest_en,
  input  logic sqe_off,
  output logic col
);

  localparam int MAXD = max4(TEST_ON_DLY, TEST_OFF_DLY, SQE_GAP, SQE_LEN);
  localparam int CW   = $clog2(MAXD + 1);

  logic rst_s;
  logic tx_d;
  logic tx_rise, tx_fall;
  logic test_col, sqe_col;
  logic sqe_arm;

  mcol_rst_sync #(.STAGES(RST_STAGES)) i_rst (
    .clk    (clk),
    .rst_ni (rst_n),
    .rst_no (rst_s)
  );

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) tx_d <= 1'b0;
    else        tx_d <= tx_en;
  end

  assign tx_rise = tx_en && !tx_d;
  assign tx_fall = !tx_en && tx_d;
  assign sqe_arm = speed10 && !full_dup && !sqe_off;

  mcol_test_timer #(
    .ON_DLY  (TEST_ON_DLY),
    .OFF_DLY (TEST_OFF_DLY),
    .CW      (CW)
  ) i_test (
    .clk      (clk),
    .rst_n    (rst_s),
    .tick     (bit_tick),
    .en       (ctest_en),
    .tx_en    (tx_en),
    .tx_rise  (tx_rise),
    .test_col (test_col)
  );

  mcol_sqe_timer #(
    .GAP_LEN   (SQE_GAP),
    .PULSE_LEN (SQE_LEN),
    .CW        (CW)
  ) i_sqe (
    .clk     (clk),
    .rst_n   (rst_s),
    .tick    (bit_tick),
    .tx_en   (tx_en),
    .tx_fall (tx_fall),
    .arm_ok  (sqe_arm),
    .sqe_col (sqe_col)
  );

  mcol_out i_out (
    .clk      (clk),
    .rst_n    (rst_s),
    .tx_en    (tx_en),
    .rx_act   (rx_act),
    .full_dup (full_dup),
    .test_col (test_col),
    .sqe_col  (sqe_col),
    .col      (col)
  );

endmodule

// File: rtl/mcol_chk.sv
module mcol_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_en,
  input logic rx_act,
  input logic full_dup,
  input logic ctest_en,
  input logic col,
  input logic test_col,
  input logic sqe_col
);

  p_overlap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && rx_act && !full_dup) |=> col);

  p_fdx_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    full_dup |=> !col);

  p_test_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(test_col) |-> ($past(tx_en) && $past(ctest_en)));

  p_test_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(test_col) |-> (!$past(tx_en) || !$past(ctest_en)));

  p_test_needs_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ctest_en |=> !test_col);

  p_sqe_cancel_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sqe_col) |-> !$past(tx_en));

endmodule

bind mii_col_unit mcol_chk i_chk (
  .clk      (clk),
  .rst_n    (rst_s),
  .tx_en    (tx_en),
  .rx_act   (rx_act),
  .full_dup (full_dup),
  .ctest_en (ctest_en),
  .col      (col),
  .test_col (test_col),
  .sqe_col  (sqe_col)
);

// File: tb/test_mii_col_unit.sv
module test_mii_col_unit;

  logic clk;
  logic rst_n;
  logic bit_tick, tx_en, rx_act, full_dup, speed10, ctest_en, sqe_off;
  logic col;

  int n_vec;
  int n_bad;
  bit done;

  mii_col_unit i_mii_col_unit (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_tick (bit_tick),
    .tx_en    (tx_en),
    .rx_act   (rx_act),
    .full_dup (full_dup),
    .speed10  (speed10),
    .ctest_en (ctest_en),
    .sqe_off  (sqe_off),
    .col      (col)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input logic act, input logic exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: col actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    repeat (n) begin
      bit_tick = 1'b1;
      @(negedge clk);
      bit_tick = 1'b0;
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    bit_tick = 0; tx_en = 0; rx_act = 0; full_dup = 0;
    speed10 = 0; ctest_en = 0; sqe_off = 0;
    idle(3);
    check("R11 in reset", col, 1'b0);
    rst_n = 1'b1;
    idle(4);
    check("R11 after release", col, 1'b0);
  endtask

  task automatic t_overlap();
    tx_en = 1; rx_act = 1;
    check("R1 before edge", col, 1'b0);
    idle(1);
    check("R1 overlap", col, 1'b1);
    rx_act = 0;
    idle(1);
    check("R1 rx drop", col, 1'b0);
    rx_act = 1;
    idle(1);
    check("R1 overlap again", col, 1'b1);
    tx_en = 0;
    idle(1);
    check("R1 tx drop", col, 1'b0);
    rx_act = 0;
    idle(2);
  endtask

  task automatic t_full_dup();
    full_dup = 1; tx_en = 1; rx_act = 1;
    idle(1);
    check("R2 fdx overlap", col, 1'b0);
    full_dup = 0;
    idle(1);
    check("R2 hdx overlap", col, 1'b1);
    full_dup = 1;
    idle(1);
    check("R2 fdx mid collision", col, 1'b0);
    tx_en = 0; rx_act = 0; full_dup = 0;
    idle(2);
  endtask

  task automatic t_ctest();
    ctest_en = 1;
    tx_en = 1;
    idle(1);
    ticks(63); idle(1);
    check("R3 63 ticks", col, 1'b0);
    ticks(1); idle(1);
    check("R3 64 ticks", col, 1'b1);
    ticks(10); idle(1);
    check("R3 held", col, 1'b1);
    tx_en = 0;
    idle(1);
    check("R4 just released", col, 1'b1);
    ticks(1); idle(1);
    check("R4 1 tick", col, 1'b1);
    ticks(1); idle(1);
    check("R4 2 ticks", col, 1'b0);
    ctest_en = 0;
    idle(2);
  endtask

  task automatic t_no_test();
    tx_en = 1;
    idle(1);
    ticks(70); idle(1);
    check("R5 tx alone", col, 1'b0);
    tx_en = 0;
    idle(2);
    check("R5 after tx", col, 1'b0);
  endtask

  task automatic t_sqe();
    speed10 = 1;
    tx_en = 1; idle(2);
    tx_en = 0; idle(1);
    ticks(19); idle(1);
    check("R6 19 ticks", col, 1'b0);
    ticks(1); idle(1);
    check("R6 20 ticks", col, 1'b1);
    ticks(9); idle(1);
    check("R7 9 ticks into pulse", col, 1'b1);
    ticks(1); idle(1);
    check("R7 10 ticks into pulse", col, 1'b0);
    speed10 = 0;
    idle(2);
  endtask

  task automatic quiet_frame(input string req);
    tx_en = 1; idle(2);
    tx_en = 0; idle(1);
    ticks(20); idle(1);
    check(req, col, 1'b0);
    ticks(15); idle(1);
    check(req, col, 1'b0);
  endtask

  task automatic t_sqe_off();
    speed10 = 1; sqe_off = 1;
    quiet_frame("R8 heartbeat disabled");
    sqe_off = 0; speed10 = 0;
    idle(2);
  endtask

  task automatic t_sqe_modes();
    speed10 = 0;
    quiet_frame("R9 100M no heartbeat");
    speed10 = 1; full_dup = 1;
    quiet_frame("R9 fdx no heartbeat");
    full_dup = 0; speed10 = 0;
    idle(2);
  endtask

  task automatic t_cancel();
    speed10 = 1;
    tx_en = 1; idle(2);
    tx_en = 0; idle(1);
    ticks(10);
    tx_en = 1;
    idle(1);
    ticks(30); idle(1);
    check("R10 cancelled", col, 1'b0);
    speed10 = 0;
    tx_en = 0;
    idle(2);
    check("R10 after frame", col, 1'b0);
  endtask

  initial begin
    n_vec = 0;
    n_bad = 0;
    done = 0;
    t_reset();
    t_overlap();
    t_full_dup();
    t_ctest();
    t_no_test();
    t_sqe();
    t_sqe_off();
    t_sqe_modes();
    t_cancel();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule